// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block collects single-bit event sources and latches each one into a secondary status bit. It then folds the status bits of each group into a primary interrupt line. There are three groups: a thermal-warning source with its own primary line, an ON-pin source with its own primary line, and a bank of GPIO sources (sixteen by default) that share one primary line.

Each source has a status bit and a mask bit, both reachable through a small word-wide register port. A status bit latches on its trigger whatever its mask says, and software clears it by writing one. A primary line is registered. It is high while any status bit in its group is both set and unmasked.

All sources first pass through a synchronizer and then an edge detector. The thermal and ON-pin sources fire on both edges. Each GPIO has a 2-bit mode that picks rising, falling, both edges or high level.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status bit reads 0, every mask bit reads 1, every GPIO mode reads 00 and all three primary lines are low. The register map is: address 0 is the system status word (bit 0 thermal, bit 1 ON-pin); address 1 is the system mask word (same bit positions); address 2 is GPIO status (bit i is GPIO i); address 3 is GPIO mask; addresses 4 and 5 hold the GPIO modes, 2 bits per GPIO, with GPIO i at bits 2*(i mod 8)+1:2*(i mod 8) of word 4 + i/8.
- R2: A status bit latches on its trigger even when its mask bit is 1, and a masked status bit never raises its primary line.
- R3: A primary line goes high in the cycle after some status bit of its group is set with its mask at 0. Primary vector order used in checks: {temp, onpin, gpio}.
- R4: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A primary line falls once no unmasked status bit of its group is set.
- R5: The thermal and ON-pin status bits latch on both rising and falling edges of their inputs.
- R6: GPIO mode 00 latches only on a rising edge.
- R7: GPIO mode 01 latches only on a falling edge.
- R8: GPIO mode 10 latches on both edges.
- R9: GPIO mode 11 latches while the input is high, so the bit sets again after a clear. When an event and a clear reach the same bit in the same cycle, the bit stays set.
- R10: Unused bit positions and unused addresses (6 and 7) read 0 and ignore writes.
- R11: Reads have no side effects: reading a word twice returns the same value.
- R12: The groups are independent: activity in one group never moves another group's primary line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_warn_i | input | 1 | Thermal warning level |
| on_pin_i | input | 1 | ON pin level |
| gpio_i | input | N_GPIO | GPIO levels |
| reg_addr | input | ADDR_W | Register word address |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq_temp_o | output | 1 | Thermal primary interrupt |
| irq_onpin_o | output | 1 | ON-pin primary interrupt |
| irq_gpio_o | output | 1 | GPIO primary interrupt |

## Verification
The bench builds the block with its defaults: sixteen GPIOs, 16-bit words and two synchronizer stages. With sixteen GPIOs both mode words are populated, so a mode can be read back from each word, while addresses 6 and 7 remain unused for the R10 checks. The two-stage synchronizer fixes the latency from an input change to its status bit at three cycles. That latency lets the bench hold a level-mode GPIO high across a clear and observe that the event beats the clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   typedef enum logic [1:0] {
      TRIG_RISE  = 2'b00,
      TRIG_FALL  = 2'b01,
      TRIG_BOTH  = 2'b10,
      TRIG_LEVEL = 2'b11
   } trig_mode_e;

   localparam int MODE_W = 2;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell import irq_agg_pkg::*; #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src,
   input  logic [1:0] mode,
   input  logic       clr,
   output logic       status
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_src_cell: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   cur;
   logic                   evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], src};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur = sync_q[SYNC_STAGES-1];

   always_comb begin
      unique case (trig_mode_e'(mode))
         TRIG_RISE:  evt = cur & ~last_q;
         TRIG_FALL:  evt = ~cur & last_q;
         TRIG_BOTH:  evt = cur ^ last_q;
         TRIG_LEVEL: evt = cur;
         default:    evt = 1'b0;
      endcase
   end

   // event has priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status <= 1'b0;
      else if (evt)    status <= 1'b1;
      else if (clr)    status <= 1'b0;
   end

   // R2: an event always latches, mask plays no part here
   p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> status);
   // R4: a clear with no competing event empties the bit
   p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !status);
   // R9: a level-mode source held high keeps the bit set
   p_level_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && cur) |=> status);
endmodule

// File: rtl/irq_group.sv
module irq_group #(
   parameter int N           = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   src,
   input  logic [2*N-1:0] mode,
   input  logic [N-1:0]   clr,
   input  logic           mask_we,
   input  logic [N-1:0]   mask_wdata,
   output logic [N-1:0]   status,
   output logic [N-1:0]   mask,
   output logic           primary
);
   if (N < 1) begin : g_bad_n
      $error("irq_group: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_cell
      irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .src    (src[i]),
         .mode   (mode[2*i +: 2]),
         .clr    (clr[i]),
         .status (status[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '1;
      else if (mask_we) mask <= mask_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primary <= 1'b0;
      else        primary <= |(status & ~mask);
   end

   // R2: a fully masked group stays silent
   p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |=> !primary);
   // R3: an unmasked pending bit reaches the primary line next cycle
   p_unmasked_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ~mask)) |=> primary);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator import irq_agg_pkg::*; #(
   parameter int N_GPIO      = 16,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              therm_warn_i,
   input  logic              on_pin_i,
   input  logic [N_GPIO-1:0] gpio_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_temp_o,
   output logic              irq_onpin_o,
   output logic              irq_gpio_o
);
   localparam int MODES_PER_WORD = DATA_W / MODE_W;
   localparam int MODE_WORDS     = (N_GPIO + MODES_PER_WORD - 1) / MODES_PER_WORD;
   localparam int A_SYS_STAT     = 0;
   localparam int A_SYS_MASK     = 1;
   localparam int A_GPIO_STAT    = 2;
   localparam int A_GPIO_MASK    = 3;
   localparam int A_MODE0        = 4;
   localparam int BIT_TEMP       = 0;
   localparam int BIT_ONPIN      = 1;

   if (N_GPIO < 1 || N_GPIO > DATA_W) begin : g_bad_gpio
      $error("irq_aggregator: N_GPIO must be 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("irq_aggregator: DATA_W must be at least 2");
   end
   if (A_MODE0 + MODE_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_aggregator: ADDR_W too small for mode words");
   end

   logic wr_sys_stat, wr_sys_mask, wr_gpio_stat, wr_gpio_mask;
   assign wr_sys_stat  = reg_wen && (reg_addr == ADDR_W'(A_SYS_STAT));
   assign wr_sys_mask  = reg_wen && (reg_addr == ADDR_W'(A_SYS_MASK));
   assign wr_gpio_stat = reg_wen && (reg_addr == ADDR_W'(A_GPIO_STAT));
   assign wr_gpio_mask = reg_wen && (reg_addr == ADDR_W'(A_GPIO_MASK));

   logic [MODE_W*N_GPIO-1:0] gpio_mode;

   for (genvar i = 0; i < N_GPIO; i++) begin : g_mode
      localparam int WORD = A_MODE0 + i / MODES_PER_WORD;
      localparam int POS  = (i % MODES_PER_WORD) * MODE_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gpio_mode[MODE_W*i +: MODE_W] <= TRIG_RISE;
         else if (reg_wen && reg_addr == ADDR_W'(WORD))
            gpio_mode[MODE_W*i +: MODE_W] <= reg_wdata[POS +: MODE_W];
      end
   end

   logic temp_stat, temp_mask, on_stat, on_mask;
   logic [N_GPIO-1:0] gpio_stat, gpio_mask;

   irq_group #(.N(1), .SYNC_STAGES(SYNC_STAGES)) u_temp (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (therm_warn_i),
      .mode       (TRIG_BOTH),
      .clr        (wr_sys_stat & reg_wdata[BIT_TEMP]),
      .mask_we    (wr_sys_mask),
      .mask_wdata (reg_wdata[BIT_TEMP]),
      .status     (temp_stat),
      .mask       (temp_mask),
      .primary    (irq_temp_o)
   );

   irq_group #(.N(1), .SYNC_STAGES(SYNC_STAGES)) u_onpin (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (on_pin_i),
      .mode       (TRIG_BOTH),
      .clr        (wr_sys_stat & reg_wdata[BIT_ONPIN]),
      .mask_we    (wr_sys_mask),
      .mask_wdata (reg_wdata[BIT_ONPIN]),
      .status     (on_stat),
      .mask       (on_mask),
      .primary    (irq_onpin_o)
   );

   irq_group #(.N(N_GPIO), .SYNC_STAGES(SYNC_STAGES)) u_gpio (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (gpio_i),
      .mode       (gpio_mode),
      .clr        ({N_GPIO{wr_gpio_stat}} & reg_wdata[N_GPIO-1:0]),
      .mask_we    (wr_gpio_mask),
      .mask_wdata (reg_wdata[N_GPIO-1:0]),
      .status     (gpio_stat),
      .mask       (gpio_mask),
      .primary    (irq_gpio_o)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_SYS_STAT)) begin
         reg_rdata[BIT_TEMP]  = temp_stat;
         reg_rdata[BIT_ONPIN] = on_stat;
      end else if (reg_addr == ADDR_W'(A_SYS_MASK)) begin
         reg_rdata[BIT_TEMP]  = temp_mask;
         reg_rdata[BIT_ONPIN] = on_mask;
      end else if (reg_addr == ADDR_W'(A_GPIO_STAT)) begin
         reg_rdata[N_GPIO-1:0] = gpio_stat;
      end else if (reg_addr == ADDR_W'(A_GPIO_MASK)) begin
         reg_rdata[N_GPIO-1:0] = gpio_mask;
      end else begin
         for (int i = 0; i < N_GPIO; i++) begin
            if (reg_addr == ADDR_W'(A_MODE0 + i / MODES_PER_WORD))
               reg_rdata[(i % MODES_PER_WORD) * MODE_W +: MODE_W] =
                  gpio_mode[MODE_W*i +: MODE_W];
         end
      end
   end

   // R12: a system-group write never touches GPIO status
   p_groups_apart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sys_stat && gpio_stat != '0 && gpio_i == '0 && gpio_mode == '0)
      |=> gpio_stat == $past(gpio_stat));
endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
   localparam int N_GPIO = 16;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              therm = 1'b0;
   logic              onpin = 1'b0;
   logic [N_GPIO-1:0] gpio = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wen = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq_t, irq_o, irq_g;

   always #10 clk = ~clk;

   irq_aggregator #(.N_GPIO(N_GPIO), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq_aggregator (
      .clk          (clk),
      .rst_n        (rst_n),
      .therm_warn_i (therm),
      .on_pin_i     (onpin),
      .gpio_i       (gpio),
      .reg_addr     (addr),
      .reg_wen      (wen),
      .reg_wdata    (wdata),
      .reg_rdata    (rdata),
      .irq_temp_o   (irq_t),
      .irq_onpin_o  (irq_o),
      .irq_gpio_o   (irq_g)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;
   logic         chk_req = 1'b0;
   logic [15:0]  exp_q [$];
   bit           kind_q [$];
   string        tag_q [$];

   // monitor: pops expected items and compares with what the design shows
   always @(negedge clk) begin
      if (chk_req && exp_q.size() > 0) begin
         logic [15:0] e, a;
         bit          k;
         string       t;
         e = exp_q.pop_front();
         k = kind_q.pop_front();
         t = tag_q.pop_front();
         a = k ? {13'd0, irq_t, irq_o, irq_g} : rdata;
         tests++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, a, e);
         end
      end
   end

   task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string t);
      @(posedge clk); #1;
      addr = a;
      exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
      chk_req = 1'b1;
      @(negedge clk); #1;
      chk_req = 1'b0;
   endtask

   task automatic chk_irq(input logic [2:0] e, input string t);
      @(posedge clk); #1;
      exp_q.push_back({13'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
      chk_req = 1'b1;
      @(negedge clk); #1;
      chk_req = 1'b0;
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; wen = 1'b1;
      @(posedge clk); #1;
      wen = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk_rd(3'd0, 16'h0000, "R1 sys status");
      chk_rd(3'd1, 16'h0003, "R1 sys mask");
      chk_rd(3'd2, 16'h0000, "R1 gpio status");
      chk_rd(3'd3, 16'hFFFF, "R1 gpio mask");
      chk_rd(3'd4, 16'h0000, "R1 mode word0");
      chk_rd(3'd5, 16'h0000, "R1 mode word1");
      chk_irq(3'b000, "R1 primaries low");

      // R2: latch while masked, no primary
      therm = 1'b1; settle();
      chk_rd(3'd0, 16'h0001, "R2 thermal latched masked");
      chk_irq(3'b000, "R2 masked silent");
      onpin = 1'b1; settle();
      chk_rd(3'd0, 16'h0003, "R2 onpin latched masked");

      // R4: write zero no effect, write one clears
      wr(3'd0, 16'h0000);
      chk_rd(3'd0, 16'h0003, "R4 write zero keeps");
      wr(3'd0, 16'h0001);
      chk_rd(3'd0, 16'h0002, "R4 write one clears thermal");

      // R5: falling edge on thermal latches
      therm = 1'b0; settle();
      chk_rd(3'd0, 16'h0003, "R5 thermal falling edge");

      // R3 / R12: unmask thermal only
      wr(3'd1, 16'h0002);
      chk_irq(3'b100, "R3 thermal primary, R12 others low");

      // R4: clearing the only unmasked bit drops primary
      wr(3'd0, 16'h0001);
      chk_irq(3'b000, "R4 primary falls after clear");
      chk_rd(3'd0, 16'h0002, "R4 onpin untouched");

      // GPIO modes: g0 rise, g1 fall, g2 both, g3 level
      wr(3'd4, 16'h00E4);
      chk_rd(3'd4, 16'h00E4, "R1 mode readback word0");
      wr(3'd5, 16'h4000);
      chk_rd(3'd5, 16'h4000, "R1 mode readback word1");
      wr(3'd5, 16'h0000);

      gpio[3:0] = 4'b1111; settle();
      chk_rd(3'd2, 16'h000D, "R6 R7 R8 R9 rising pattern");
      wr(3'd2, 16'hFFFF);
      chk_rd(3'd2, 16'h0008, "R9 level re-sets, event beats clear");
      gpio[3:0] = 4'b0000; settle();
      chk_rd(3'd2, 16'h000E, "R7 R8 falling pattern");
      wr(3'd2, 16'hFFFF);
      chk_rd(3'd2, 16'h0000, "R4 gpio all cleared");

      // R3 / R12: gpio primary
      wr(3'd3, 16'hFFF7);
      chk_irq(3'b000, "R3 nothing pending");
      gpio[3] = 1'b1; settle();
      chk_irq(3'b001, "R3 R12 gpio primary only");
      wr(3'd2, 16'h0008);
      chk_irq(3'b001, "R9 clear loses to level");
      gpio[3] = 1'b0; settle();
      wr(3'd2, 16'h0008);
      chk_irq(3'b000, "R4 gpio primary falls");

      // R10: unused bits and addresses
      wr(3'd1, 16'hFFFC);
      chk_rd(3'd1, 16'h0000, "R10 upper mask bits ignored");
      chk_irq(3'b010, "R3 onpin primary");
      wr(3'd6, 16'hFFFF);
      chk_rd(3'd6, 16'h0000, "R10 addr6 reads zero");
      chk_rd(3'd7, 16'h0000, "R10 addr7 reads zero");

      // R11: reads have no side effects
      chk_rd(3'd0, 16'h0002, "R11 first read");
      chk_rd(3'd0, 16'h0002, "R11 second read");
      chk_irq(3'b010, "R11 primary unchanged by reads");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule